// File: doc/BRIEF.md
# Dual-Edge Video Byte Capture and Pixel Assembly

This block sits at a video input pin group and rebuilds whole pixels from an 8-bit data bus. Depending on the selected format, the bus carries bytes on both edges of the pixel clock or on rising edges only. The falling-edge byte is held in a half-cycle register and joined with the byte sampled at the next rising edge. All outputs are produced in the rising-edge domain.

Four formats are supported. Two are packed RGB formats, one with 5-bit green and one with 6-bit green. The other two carry 4:2:2 luma/chroma: one at double data rate and one as a rising-edge-only byte stream. A line-start pulse loads the pending format choice and restarts chroma sequencing. It also throws away any partly assembled pixel.

Top module: `ddr_pixel_capture`

## Requirements
- R1: After reset, `pix_vld` is 0, `pix_out` is 0, and the active format is 15-bit RGB (select code 0). A sync is not needed for RGB pixels to flow.
- R2: The format codes on `fmt_sel` are: 0 = 15-bit RGB, 1 = 16-bit RGB, 2 = double-rate 4:2:2, 3 = single-edge 4:2:2. `fmt_sel` is sampled only on a rising edge where `sync` is 1. At any other time a change of `fmt_sel` has no effect on the output.
- R3: A rising edge with `sync` high produces no valid pixel and drops any partial pixel or held luma. The first 4:2:2 sample after that edge is taken as Cb.
- R4: 15-bit RGB. Take the falling byte F and the following rising byte S. Then red = S[6:2], green = {S[1:0], F[7:5]} and blue = F[4:0]. `pix_out` = {8'h00, 1'b0, red, green, blue}, and S[7] is ignored.
- R5: 16-bit RGB. Blue and the low green bits come from F as in R4. Red = S[7:3] and green = {S[2:0], F[7:5]}. `pix_out` = {8'h00, red, green, blue}.
- R6: In both RGB formats, every rising edge without sync yields exactly one valid pixel. That pixel is built from the falling byte half a period earlier and the byte sampled at that edge.
- R7: Double-rate 4:2:2. The first cycle after sync carries Cb (falling) and Y0 (rising), and the next cycle carries Cr and Y1. The output word is {Y, Cb, Cr} in bits [23:16], [15:8] and [7:0]. {Y0, Cb, Cr} becomes valid at the edge that samples Y1.
- R8: Single-edge 4:2:2. Rising-edge bytes repeat in the order Cb, Y0, Cr, Y1. {Y0, Cb, Cr} is valid at the Cr edge and {Y1, Cb, Cr} at the Y1 edge. The Cb and Y0 edges carry no valid pixel.
- R9: In double-rate 4:2:2, the held {Y1, Cb, Cr} is output at the edge that captures the next pair's Cb and Y0. From the second cycle after sync, valid therefore stays high every cycle. A sync on that edge drops the held Y1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; both edges sample `pd` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Line-start pulse, sampled on rising edges |
| fmt_sel | input | 2 | Pending format code, loaded on sync |
| pd | input | 8 | Video data bus |
| pix_out | output | 24 | Assembled pixel word |
| pix_vld | output | 1 | One-cycle strobe per delivered pixel |

## Verification
In double-rate 4:2:2, two tasks share one rising edge: delivering the held Y1 of one pair and capturing Cb/Y0 of the next. A line-start pulse can also land on that edge and must cancel the delivery. The bench places sync pulses after both even and odd cycle counts in this mode, and in the middle of single-edge groups. A behavioural model indexes queues of the bytes received since the last sync, and the bench compares `pix_vld` and `pix_out` with it after every rising edge. It also changes `fmt_sel` without a sync to confirm the output decoding does not move.

// File: rtl/ddr_pixel_capture.sv
module ddr_pixel_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync,
  input  logic [1:0]  fmt_sel,
  input  logic [7:0]  pd,
  output logic [23:0] pix_out,
  output logic        pix_vld
);

  localparam logic [1:0] F_RGB15  = 2'd0;
  localparam logic [1:0] F_RGB16  = 2'd1;
  localparam logic [1:0] F_YC_DDR = 2'd2;
  localparam logic [1:0] F_YC_SDR = 2'd3;

  logic [7:0] fall_q;
  logic [1:0] fmt_q, ph_q;
  logic [7:0] cb_q, cr_q, y_q;
  logic       y1_pend;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_q <= '0;
    else        fall_q <= pd;

  wire [15:0] rgb15 = {1'b0, pd[6:2], pd[1:0], fall_q[7:5], fall_q[4:0]};
  wire [15:0] rgb16 = {pd[7:3], pd[2:0], fall_q[7:5], fall_q[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= F_RGB15;
      ph_q    <= '0;
      cb_q    <= '0;
      cr_q    <= '0;
      y_q     <= '0;
      y1_pend <= 1'b0;
      pix_out <= '0;
      pix_vld <= 1'b0;
    end else if (sync) begin
      fmt_q   <= fmt_sel;
      ph_q    <= '0;
      y1_pend <= 1'b0;
      pix_vld <= 1'b0;
    end else begin
      unique case (fmt_q)
        F_RGB15: begin
          pix_vld <= 1'b1;
          pix_out <= {8'h00, rgb15};
        end
        F_RGB16: begin
          pix_vld <= 1'b1;
          pix_out <= {8'h00, rgb16};
        end
        F_YC_DDR: begin
          ph_q[0] <= ~ph_q[0];
          if (!ph_q[0]) begin
            pix_vld <= y1_pend;
            if (y1_pend) pix_out <= {y_q, cb_q, cr_q};
            cb_q <= fall_q;
            y_q  <= pd;
          end else begin
            pix_vld <= 1'b1;
            pix_out <= {y_q, cb_q, fall_q};
            cr_q    <= fall_q;
            y_q     <= pd;
            y1_pend <= 1'b1;
          end
        end
        F_YC_SDR: begin
          ph_q <= ph_q + 2'd1;
          unique case (ph_q)
            2'd0: begin cb_q <= pd; pix_vld <= 1'b0; end
            2'd1: begin y_q  <= pd; pix_vld <= 1'b0; end
            2'd2: begin
              cr_q    <= pd;
              pix_vld <= 1'b1;
              pix_out <= {y_q, cb_q, pd};
            end
            default: begin
              pix_vld <= 1'b1;
              pix_out <= {pd, cb_q, cr_q};
            end
          endcase
        end
        default: pix_vld <= 1'b0;
      endcase
    end
  end

  assert_sync_blanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !pix_vld);

  assert_fmt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(fmt_q));

  assert_rgb_every_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_q[1] && !sync) |=> pix_vld);

  assert_rgb_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !fmt_q[1]) |-> (pix_out[23:16] == 8'h00));

  assert_rgb15_top_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && fmt_q == F_RGB15) |-> !pix_out[15]);

  assert_ddr_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == F_YC_DDR && pix_vld && !sync) |=> pix_vld);

  assert_sdr_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == F_YC_SDR && pix_vld && $past(pix_vld) && !sync) |=> !pix_vld);

  assert_sdr_chroma_shared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == F_YC_SDR && pix_vld && $past(pix_vld)) |-> (pix_out[15:0] == $past(pix_out[15:0])));

endmodule

// File: tb/tb_ddr_pixel_capture.sv
module tb_ddr_pixel_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [7:0]  pd = 8'h00;
  logic [23:0] pix_out;
  logic        pix_vld;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int mode = 0;
  logic [7:0] fq[$];
  logic [7:0] rq[$];
  string ovr = "";

  ddr_pixel_capture dut (.clk(clk), .rst_n(rst_n), .sync(sync), .fmt_sel(fmt_sel),
                         .pd(pd), .pix_out(pix_out), .pix_vld(pix_vld));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] gen(input int k);
    return 8'((k * 73 + 29) ^ (k >> 2));
  endfunction

  task automatic cyc(input logic [7:0] fb, input logic [7:0] rb, input logic s, input logic [1:0] fs);
    logic       ev;
    logic [23:0] ep;
    string      tv, tp;
    int         c;
    pd = fb; sync = 1'b0;
    @(negedge clk); #1;
    pd = rb; sync = s; fmt_sel = fs;
    @(posedge clk); #1;
    ev = 1'b0; ep = '0; tv = "R3"; tp = "R3";
    if (s) begin
      mode = fs; fq.delete(); rq.delete();
    end else if (mode < 2) begin
      ev = 1'b1; tv = "R6";
      if (mode == 0) begin ep = {8'h00, 1'b0, rb[6:2], rb[1:0], fb[7:5], fb[4:0]}; tp = "R4"; end
      else           begin ep = {8'h00, rb[7:3], rb[2:0], fb[7:5], fb[4:0]};       tp = "R5"; end
    end else if (mode == 2) begin
      fq.push_back(fb); rq.push_back(rb);
      c = fq.size() - 1;
      if (c % 2 == 1) begin ev = 1'b1; ep = {rq[c-1], fq[c-1], fq[c]}; tv = "R7"; tp = "R7"; end
      else if (c >= 2) begin ev = 1'b1; ep = {rq[c-1], fq[c-2], fq[c-1]}; tv = "R9"; tp = "R9"; end
    end else begin
      rq.push_back(rb);
      c = rq.size() - 1;
      tv = "R8"; tp = "R8";
      if (c % 4 == 2) begin ev = 1'b1; ep = {rq[c-1], rq[c-2], rq[c]}; end
      else if (c % 4 == 3) begin ev = 1'b1; ep = {rq[c], rq[c-3], rq[c-1]}; end
    end
    if (ovr != "") begin tv = ovr; tp = ovr; end
    chk(pix_vld === ev, tv, {23'd0, pix_vld}, {23'd0, ev});
    if (ev) chk(pix_out === ep, tp, pix_out, ep);
  endtask

  task automatic run(input int n, input int base, input logic [1:0] fs);
    for (int i = 0; i < n; i++) cyc(gen(base + 2*i), gen(base + 2*i + 1), 1'b0, fs);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(pix_vld === 1'b0 && pix_out === 24'h0, "R1", pix_out, 24'h0);
    rst_n = 1'b1;

    ovr = "R1";
    for (int i = 0; i < 4; i++) cyc(gen(i), gen(i + 50) | 8'h80, 1'b0, 2'd0);
    ovr = "R2";
    for (int i = 0; i < 6; i++) cyc(gen(i + 7), gen(i + 90) | 8'h80, 1'b0, 2'd1);
    ovr = "";

    cyc(8'h11, 8'h22, 1'b1, 2'd1);  run(8, 100, 2'd1);
    cyc(8'h33, 8'h44, 1'b1, 2'd0);  run(6, 200, 2'd0);

    cyc(8'h55, 8'h66, 1'b1, 2'd2);  run(9, 300, 2'd2);
    cyc(8'h77, 8'h88, 1'b1, 2'd2);  run(4, 400, 2'd2);
    cyc(8'h99, 8'hAA, 1'b1, 2'd2);  run(1, 500, 2'd2);
    cyc(8'hBB, 8'hCC, 1'b1, 2'd2);  run(6, 600, 2'd2);

    cyc(8'hDD, 8'hEE, 1'b1, 2'd3);  run(10, 700, 2'd3);
    cyc(8'h01, 8'h02, 1'b1, 2'd3);  run(9, 800, 2'd3);

    cyc(8'h03, 8'h04, 1'b1, 2'd2);  run(40, 900, 2'd2);
    cyc(8'h05, 8'h06, 1'b1, 2'd3);  run(40, 1000, 2'd3);
    cyc(8'h07, 8'h08, 1'b1, 2'd1);  run(20, 1100, 2'd0);
    cyc(8'h09, 8'h0A, 1'b1, 2'd0);  run(10, 1200, 2'd3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule